// File: doc/BRIEF.md
# Protected Flash Command Decoder

This block sits on the write side of a word-wide, two-bank flash bus and turns guarded write sequences into single operation requests. Software must unlock the part with two fixed writes before any program, erase or identification command is accepted. The decoder watches one write strobe per bus write and follows the sequence through its steps. When a sequence completes, it raises a one-cycle command pulse. The pulse carries the operation type, the target bank, and either the erase region or the program word address and data. The array, the operation timers and the status responder sit beside it and consume that pulse.

The decoder also keeps an identification-mode flag. While the flag is set, a read port returns the maker code and a per-bank device code. All other operations are refused until the exit command is given. A per-bank busy input freezes the decoder while any program or erase is running. Reads and idle cycles between the writes of a sequence leave its progress untouched.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `cmd_valid` and `id_mode` are 0 and the decoder waits for the first unlock write.
- R2: The sequence 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then any write (A, D) gives one cycle of `cmd_valid` in the cycle after the last strobe. In that cycle `cmd_op`=0 (program), `cmd_bank`=A[18], `cmd_addr`=A[17:0] and `cmd_data`=D. In the next cycle `cmd_valid` is 0.
- R3: The two unlock writes, 0x80 to 0x5555, the two unlock writes again, then 0x30 to address A give `cmd_op`=1 (sector erase), `cmd_bank`=A[18] and `cmd_addr`={A[17:10], ten zeros}.
- R4: The same erase prefix with final data 0x50 at address A gives `cmd_op`=2 (block erase), `cmd_bank`=A[18] and `cmd_addr`={A[17:15], fifteen zeros}.
- R5: The erase prefix with final data 0x10 gives `cmd_op`=3 (bank erase), `cmd_bank`=A[18] and `cmd_addr`=0, but only when A[14:0]=0x5555. At any other address, no command is issued.
- R6: Command cycles compare only address bits 14..0 and data bits 7..0. Bits 17..15 of the address and bits 15..8 of the data have no effect on recognition.
- R7: A write whose address or data does not fit the current step abandons the sequence. The rest of the steps alone then issue nothing; a full sequence from the first unlock write is needed.
- R8: While any bit of `busy` is 1, strobed writes are ignored and the progress of a sequence is held. Its later steps still complete it once `busy` returns to 0, and a full sequence given under busy issues nothing.
- R9: Third-step data 0x90 sets `id_mode`. While it is set and `rd_addr[14:1]`=0, `id_valid`=1. `id_data` is 0x0062 when `rd_addr[0]`=0, and when `rd_addr[0]`=1 it is 0x2533 for `rd_addr[18]`=0 or 0x2534 for `rd_addr[18]`=1.
- R10: `id_valid` and `id_data` are 0 when `id_mode` is 0 or when `rd_addr[14:1]` is not 0.
- R11: While `id_mode` is set, program and erase sequences issue no command. Third-step data 0xF0 clears `id_mode`.
- R12: Cycles without a strobe, with any read address, leave the progress of a sequence and `id_mode` unchanged.
- R13: The 0xF0 command given outside identification mode changes nothing: `id_mode` stays 0 and a following program sequence works.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe marking a bus write |
| wr_addr | input | 19 | Write address; bit 18 selects the bank |
| wr_data | input | 16 | Write data |
| busy | input | 2 | Per-bank program/erase in progress |
| rd_addr | input | 19 | Read address for identification codes |
| cmd_valid | output | 1 | One-cycle operation request |
| cmd_op | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 bank erase |
| cmd_bank | output | 1 | Target bank |
| cmd_addr | output | 18 | Word address, or erase region aligned to its size |
| cmd_data | output | 16 | Program data (0 for erases) |
| id_mode | output | 1 | Identification mode active |
| id_valid | output | 1 | `id_data` holds an identification code |
| id_data | output | 16 | Identification code |

## Verification
The assertions assume that `wr_stb` is a single-cycle pulse with at least one idle cycle after it. They also assume that `busy` only changes away from the clock edge, so a frozen cycle is compared with the cycle before it. The bench drives every input on the falling edge and brings each strobe back to 0 before the next write, with a gap cycle between writes. It raises `busy` only between sequence steps, which keeps the stimulus inside those assumptions while still reaching abort, freeze and identification-mode paths.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
   typedef enum logic [1:0] {
      OP_PROG  = 2'd0,
      OP_SECT  = 2'd1,
      OP_BLOCK = 2'd2,
      OP_BANK  = 2'd3
   } fcd_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNL1,
      ST_UNL2,
      ST_PGM,
      ST_ER3,
      ST_ER4,
      ST_ER5
   } fcd_state_e;
endpackage

// File: rtl/fcd_match.sv
// Compares one write cycle against a fixed address and, optionally, a data byte.
module fcd_match #(
   parameter int          CMP_W    = 15,
   parameter int          BYTE_W   = 8,
   parameter logic [31:0] EXP_ADDR = 32'h5555,
   parameter logic [7:0]  EXP_DATA = 8'hAA,
   parameter bit          USE_DATA = 1'b1
) (
   input  logic [CMP_W-1:0]  addr_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic              hit_o
);
   logic addr_ok;
   assign addr_ok = (addr_i == EXP_ADDR[CMP_W-1:0]);

   generate
      if (USE_DATA) begin : g_with_data
         assign hit_o = addr_ok && (byte_i == EXP_DATA[BYTE_W-1:0]);
      end else begin : g_addr_only
         logic unused_byte;
         assign unused_byte = ^byte_i;
         assign hit_o = addr_ok;
      end
   endgenerate
endmodule

// File: rtl/fcd_seq.sv
// Sequence tracker: unlock steps, command byte, erase prefix, final cycle.
module fcd_seq
   import fcd_pkg::*;
#(
   parameter int         ADDR_W   = 19,
   parameter int         DATA_W   = 16,
   parameter int         CMP_W    = 15,
   parameter int         NBANK    = 2,
   parameter int         SECT_LSB = 10,
   parameter int         BLK_LSB  = 15,
   parameter logic [7:0] C_ID_IN  = 8'h90,
   parameter logic [7:0] C_ID_OUT = 8'hF0,
   parameter logic [7:0] C_PROG   = 8'hA0,
   parameter logic [7:0] C_ERASE  = 8'h80,
   parameter logic [7:0] C_SECT   = 8'h30,
   parameter logic [7:0] C_BLOCK  = 8'h50,
   parameter logic [7:0] C_BANK   = 8'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [NBANK-1:0]  busy_i,
   input  logic              hit_aa_i,
   input  logic              hit_55_i,
   input  logic              hit_cmd_i,
   output logic              cmd_valid_o,
   output logic [1:0]        cmd_op_o,
   output logic              cmd_bank_o,
   output logic [ADDR_W-2:0] cmd_addr_o,
   output logic [DATA_W-1:0] cmd_data_o,
   output logic              id_mode_o
);
   localparam int OFS_W    = ADDR_W - 1;
   localparam int BANK_BIT = ADDR_W - 1;

   fcd_state_e        st_q, st_d;
   logic              id_q, id_d;
   logic              fire;
   fcd_op_e           op_d;
   logic              bank_d;
   logic [OFS_W-1:0]  ofs_d;
   logic [DATA_W-1:0] dat_d;
   logic [7:0]        cbyte;
   logic              take;

   logic              vld_q;
   fcd_op_e           op_q;
   logic              bank_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [DATA_W-1:0] dat_q;

   assign cbyte = data_i[7:0];
   assign take  = stb_i && !(|busy_i);

   always_comb begin
      st_d   = st_q;
      id_d   = id_q;
      fire   = 1'b0;
      op_d   = OP_PROG;
      bank_d = addr_i[BANK_BIT];
      ofs_d  = '0;
      dat_d  = '0;
      if (take) begin
         st_d = ST_IDLE;
         case (st_q)
            ST_IDLE: if (hit_aa_i) st_d = ST_UNL1;
            ST_UNL1: if (hit_55_i) st_d = ST_UNL2;
            ST_UNL2: begin
               if (hit_cmd_i) begin
                  if (cbyte == C_ID_IN)                    id_d = 1'b1;
                  else if (cbyte == C_ID_OUT)              id_d = 1'b0;
                  else if (!id_q && cbyte == C_PROG)       st_d = ST_PGM;
                  else if (!id_q && cbyte == C_ERASE)      st_d = ST_ER3;
               end
            end
            ST_PGM: begin
               fire  = 1'b1;
               op_d  = OP_PROG;
               ofs_d = addr_i[OFS_W-1:0];
               dat_d = data_i;
            end
            ST_ER3: if (hit_aa_i) st_d = ST_ER4;
            ST_ER4: if (hit_55_i) st_d = ST_ER5;
            ST_ER5: begin
               if (cbyte == C_SECT) begin
                  fire = 1'b1;
                  op_d = OP_SECT;
                  ofs_d[OFS_W-1:SECT_LSB] = addr_i[OFS_W-1:SECT_LSB];
               end else if (cbyte == C_BLOCK) begin
                  fire = 1'b1;
                  op_d = OP_BLOCK;
                  ofs_d[OFS_W-1:BLK_LSB] = addr_i[OFS_W-1:BLK_LSB];
               end else if (cbyte == C_BANK && hit_cmd_i) begin
                  fire = 1'b1;
                  op_d = OP_BANK;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         id_q   <= 1'b0;
         vld_q  <= 1'b0;
         op_q   <= OP_PROG;
         bank_q <= 1'b0;
         ofs_q  <= '0;
         dat_q  <= '0;
      end else begin
         st_q  <= st_d;
         id_q  <= id_d;
         vld_q <= fire;
         if (fire) begin
            op_q   <= op_d;
            bank_q <= bank_d;
            ofs_q  <= ofs_d;
            dat_q  <= dat_d;
         end
      end
   end

   assign cmd_valid_o = vld_q;
   assign cmd_op_o    = op_q;
   assign cmd_bank_o  = bank_q;
   assign cmd_addr_o  = ofs_q;
   assign cmd_data_o  = dat_q;
   assign id_mode_o   = id_q;

   // R2: a request lasts one cycle
   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q);
   // R2: a request only follows a strobed write
   p_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> $past(stb_i));
   // R8: busy freezes sequence progress and mode
   p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|busy_i) |=> (st_q == $past(st_q)) && (id_q == $past(id_q)) && !vld_q);
   // R12: cycles without a strobe change nothing
   p_quiet_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_i |=> $stable(st_q) && $stable(id_q));
   // R11: no operation is requested while identification mode is set
   p_id_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> !id_q);
endmodule

// File: rtl/fcd_id_rom.sv
// Identification code read port.
module fcd_id_rom #(
   parameter int           ADDR_W   = 19,
   parameter int           DATA_W   = 16,
   parameter int           CMP_W    = 15,
   parameter bit           ID_REG   = 1'b0,
   parameter logic [15:0]  MAKER_ID = 16'h0062,
   parameter logic [15:0]  DEV_ID0  = 16'h2533,
   parameter logic [15:0]  DEV_ID1  = 16'h2534
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              id_mode_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic              id_valid_o,
   output logic [DATA_W-1:0] id_data_o
);
   logic              sel;
   logic [DATA_W-1:0] code;

   assign sel  = id_mode_i && (rd_addr_i[CMP_W-1:1] == '0);
   assign code = !rd_addr_i[0]         ? DATA_W'(MAKER_ID) :
                 rd_addr_i[ADDR_W-1]   ? DATA_W'(DEV_ID1)  : DATA_W'(DEV_ID0);

   generate
      if (ID_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               id_valid_o <= 1'b0;
               id_data_o  <= '0;
            end else begin
               id_valid_o <= sel;
               id_data_o  <= sel ? code : '0;
            end
         end
      end else begin : g_comb
         assign id_valid_o = sel;
         assign id_data_o  = sel ? code : '0;
         // R10: codes appear only in identification mode
         p_id_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
            id_valid_o |-> id_mode_i);
         // R10: a silent read port drives zero data
         p_id_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !id_valid_o |-> (id_data_o == '0));
      end
   endgenerate
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 16,
   parameter int CMP_W    = 15,
   parameter int NBANK    = 2,
   parameter int SECT_LSB = 10,
   parameter int BLK_LSB  = 15,
   parameter bit ID_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [18:0]       wr_addr,
   input  logic [15:0]       wr_data,
   input  logic [1:0]        busy,
   input  logic [18:0]       rd_addr,
   output logic              cmd_valid,
   output logic [1:0]        cmd_op,
   output logic              cmd_bank,
   output logic [17:0]       cmd_addr,
   output logic [15:0]       cmd_data,
   output logic              id_mode,
   output logic              id_valid,
   output logic [15:0]       id_data
);
   localparam int BYTE_W = 8;

   generate
      if (ADDR_W != 19 || DATA_W != 16 || NBANK != 2)
         $error("port widths are fixed at 19/16/2");
      if (CMP_W >= ADDR_W - 1 || CMP_W < 15)
         $error("CMP_W must cover 0x5555 and stay below the region bits");
      if (SECT_LSB >= BLK_LSB || BLK_LSB >= ADDR_W - 1)
         $error("sector field must be finer than the block field");
   endgenerate

   logic hit_aa, hit_55, hit_cmd;

   fcd_match #(.CMP_W(CMP_W), .BYTE_W(BYTE_W), .EXP_ADDR(32'h5555),
               .EXP_DATA(8'hAA), .USE_DATA(1'b1)) u_m_aa (
      .addr_i(wr_addr[CMP_W-1:0]), .byte_i(wr_data[BYTE_W-1:0]), .hit_o(hit_aa));

   fcd_match #(.CMP_W(CMP_W), .BYTE_W(BYTE_W), .EXP_ADDR(32'h2AAA),
               .EXP_DATA(8'h55), .USE_DATA(1'b1)) u_m_55 (
      .addr_i(wr_addr[CMP_W-1:0]), .byte_i(wr_data[BYTE_W-1:0]), .hit_o(hit_55));

   fcd_match #(.CMP_W(CMP_W), .BYTE_W(BYTE_W), .EXP_ADDR(32'h5555),
               .EXP_DATA(8'h00), .USE_DATA(1'b0)) u_m_cmd (
      .addr_i(wr_addr[CMP_W-1:0]), .byte_i(wr_data[BYTE_W-1:0]), .hit_o(hit_cmd));

   fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W), .NBANK(NBANK),
             .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)) u_seq (
      .clk(clk), .rst_n(rst_n), .stb_i(wr_stb), .addr_i(wr_addr), .data_i(wr_data),
      .busy_i(busy), .hit_aa_i(hit_aa), .hit_55_i(hit_55), .hit_cmd_i(hit_cmd),
      .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_bank_o(cmd_bank),
      .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .id_mode_o(id_mode));

   fcd_id_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W), .ID_REG(ID_REG)) u_id (
      .clk(clk), .rst_n(rst_n), .id_mode_i(id_mode), .rd_addr_i(rd_addr),
      .id_valid_o(id_valid), .id_data_o(id_data));

   // R1: nothing is requested in the first cycle after reset release
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !cmd_valid);
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [18:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  busy = '0;
   logic [18:0] rd_addr = '0;
   logic        cmd_valid, cmd_bank, id_mode, id_valid;
   logic [1:0]  cmd_op;
   logic [17:0] cmd_addr;
   logic [15:0] cmd_data, id_data;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   flash_cmd_decoder u_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .rd_addr(rd_addr), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .id_mode(id_mode), .id_valid(id_valid), .id_data(id_data));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // one strobed write; returns at the falling edge after the sampling edge
   task automatic wr(input logic [18:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_stb  = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic unlock();
      wr(19'h05555, 16'h00AA);
      wr(19'h02AAA, 16'h0055);
   endtask

   task automatic erase_prefix();
      unlock();
      wr(19'h05555, 16'h0080);
      unlock();
   endtask

   task automatic expect_cmd(input string req, input logic [1:0] op, input logic bank,
                             input logic [17:0] addr, input logic [15:0] data);
      chk({req, " valid"}, cmd_valid, 1);
      chk({req, " op"}, cmd_op, op);
      chk({req, " bank"}, cmd_bank, bank);
      chk({req, " addr"}, cmd_addr, addr);
      chk({req, " data"}, cmd_data, data);
      @(negedge clk);
      chk({req, " pulse ends"}, cmd_valid, 0);
   endtask

   task automatic t_reset_r1();
      chk("R1 cmd_valid", cmd_valid, 0);
      chk("R1 id_mode", id_mode, 0);
   endtask

   task automatic t_program_r2();
      unlock();
      wr(19'h05555, 16'h00A0);
      chk("R2 no early cmd", cmd_valid, 0);
      wr(19'h41234, 16'hBEEF);
      expect_cmd("R2 program", 2'd0, 1'b1, 18'h01234, 16'hBEEF);
   endtask

   task automatic t_sector_r3();
      erase_prefix();
      wr(19'h0ABCD, 16'h0030);
      expect_cmd("R3 sector", 2'd1, 1'b0, 18'h0A800, 16'h0000);
   endtask

   task automatic t_block_r4();
      erase_prefix();
      wr(19'h7FFFF, 16'h0050);
      expect_cmd("R4 block", 2'd2, 1'b1, 18'h38000, 16'h0000);
   endtask

   task automatic t_bank_r5();
      erase_prefix();
      wr(19'h45555, 16'h0010);
      expect_cmd("R5 bank", 2'd3, 1'b1, 18'h00000, 16'h0000);
      erase_prefix();
      wr(19'h01234, 16'h0010);
      chk("R5 bank erase wrong address", cmd_valid, 0);
   endtask

   task automatic t_high_bits_r6();
      wr(19'h3D555, 16'hFFAA);
      wr(19'h1AAAA, 16'h7755);
      wr(19'h2D555, 16'hC3A0);
      wr(19'h00042, 16'h1234);
      expect_cmd("R6 high bits ignored", 2'd0, 1'b0, 18'h00042, 16'h1234);
   endtask

   task automatic t_abort_r7();
      unlock();
      wr(19'h05555, 16'h0077);
      wr(19'h05555, 16'h00A0);
      wr(19'h00100, 16'h5A5A);
      chk("R7 bad command byte aborts", cmd_valid, 0);
      wr(19'h05555, 16'h00AA);
      wr(19'h02AAB, 16'h0055);
      wr(19'h05555, 16'h00A0);
      wr(19'h00200, 16'h1111);
      chk("R7 bad unlock address aborts", cmd_valid, 0);
      erase_prefix();
      wr(19'h05555, 16'h0020);
      chk("R7 bad erase type", cmd_valid, 0);
   endtask

   task automatic t_busy_r8();
      wr(19'h05555, 16'h00AA);
      busy = 2'b10;
      wr(19'h00000, 16'h0000);
      busy = 2'b00;
      wr(19'h02AAA, 16'h0055);
      wr(19'h05555, 16'h00A0);
      wr(19'h00077, 16'h4321);
      expect_cmd("R8 progress held across busy", 2'd0, 1'b0, 18'h00077, 16'h4321);
      busy = 2'b01;
      unlock();
      wr(19'h05555, 16'h00A0);
      wr(19'h00010, 16'h9999);
      chk("R8 sequence under busy", cmd_valid, 0);
      busy = 2'b00;
      wr(19'h00010, 16'h9999);
      chk("R8 nothing armed after busy", cmd_valid, 0);
   endtask

   task automatic t_id_r9_r10_r11();
      unlock();
      wr(19'h45555, 16'h0090);
      chk("R9 id_mode set", id_mode, 1);
      rd_addr = 19'h00000; #1;
      chk("R9 maker valid", id_valid, 1);
      chk("R9 maker code", id_data, 16'h0062);
      rd_addr = 19'h00001; #1;
      chk("R9 bank0 device", id_data, 16'h2533);
      rd_addr = 19'h40001; #1;
      chk("R9 bank1 device", id_data, 16'h2534);
      rd_addr = 19'h00002; #1;
      chk("R10 nonzero bits invalid", id_valid, 0);
      chk("R10 nonzero bits data", id_data, 16'h0000);
      unlock();
      wr(19'h05555, 16'h00A0);
      wr(19'h00005, 16'h0F0F);
      chk("R11 program refused in id mode", cmd_valid, 0);
      erase_prefix();
      wr(19'h45555, 16'h0010);
      chk("R11 erase refused in id mode", cmd_valid, 0);
      chk("R11 id_mode kept", id_mode, 1);
      unlock();
      wr(19'h05555, 16'h00F0);
      chk("R11 exit clears id_mode", id_mode, 0);
      rd_addr = 19'h00000; #1;
      chk("R10 no code outside id mode", id_valid, 0);
      chk("R10 zero data outside id mode", id_data, 16'h0000);
   endtask

   task automatic t_gaps_r12();
      wr(19'h05555, 16'h00AA);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         rd_addr = 19'(i * 4099);
      end
      wr(19'h02AAA, 16'h0055);
      repeat (3) @(negedge clk);
      wr(19'h05555, 16'h00A0);
      repeat (7) @(negedge clk);
      wr(19'h00300, 16'hCAFE);
      expect_cmd("R12 gaps between writes", 2'd0, 1'b0, 18'h00300, 16'hCAFE);
   endtask

   task automatic t_exit_idle_r13();
      unlock();
      wr(19'h05555, 16'h00F0);
      chk("R13 exit outside id mode", id_mode, 0);
      chk("R13 no request", cmd_valid, 0);
      unlock();
      wr(19'h05555, 16'h00A0);
      wr(19'h40400, 16'h0001);
      expect_cmd("R13 program after exit", 2'd0, 1'b1, 18'h00400, 16'h0001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_r1();
      t_program_r2();
      t_sector_r3();
      t_block_r4();
      t_bank_r5();
      t_high_bits_r6();
      t_abort_r7();
      t_busy_r8();
      t_id_r9_r10_r11();
      t_gaps_r12();
      t_exit_idle_r13();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule